// File: doc/BRIEF.md
# Two-Slope Integrating Converter Sequencer

This block is the digital half of a two-slope integrating analog-to-digital converter. When a start pulse arrives, it connects the external integrator to the unknown signal for a fixed number of system-clock cycles. It then clears its counter, switches the integrator to the opposite-polarity reference, and counts clock cycles until the comparator reports that the integrator output has returned to zero. The final count, corrected for the comparator synchroniser delay, is the conversion result. It is proportional to the input divided by the reference.

The same clock times the charge interval and measures the discharge interval, so its frequency cancels out of the result. A start/busy/done handshake frames each conversion. The switch-select outputs are one-hot, so the integrator always sees exactly one of signal, reference, or hold. An overrange flag marks a discharge that did not finish within the count limit.

Top module: `dslope_seq`

## Requirements
- R1: A start pulse begins a conversion only while the sequencer is idle. Busy is high from the cycle after an accepted start until the done cycle, inclusive. A start seen while busy changes neither the running conversion nor its result, and does not begin another conversion.
- R2: After an accepted start, the signal select is high for exactly N_CHARGE consecutive cycles.
- R3: The reference select rises in the cycle right after the last signal-select cycle, and the counter is zero in that first reference cycle.
- R4: The comparator input is high while the integrator output is above zero. It passes through a SYNC_STAGES flip-flop synchroniser before use. The first reference cycle is never treated as a zero crossing. When the synchronised comparator is low, the result is the count minus SYNC_STAGES, floored at zero. For an ideal integrator this is within one LSB of N_CHARGE*Vin/Vref.
- R5: For a fixed input-to-reference ratio, the result is the same at clock periods of 20 ns and 30 ns.
- R6: The discharge count never exceeds MAX_COUNT (default 2*N_CHARGE). If the count reaches MAX_COUNT, the conversion ends with the overrange flag at 1 and the result at MAX_COUNT. An in-range conversion clears the flag.
- R7: Done is high for exactly one cycle per conversion. The result and overrange flag already hold their new values in that cycle. From that cycle on, the hold select is high.
- R8: Exactly one of the signal, reference and hold selects is high in every cycle.
- R9: After reset, hold select is 1, busy and done are 0, and result and overrange are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the only timebase |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | Conversion request pulse |
| compI | input | 1 | Asynchronous comparator, 1 while integrator output is above zero |
| busyO | output | 1 | Conversion in progress |
| doneO | output | 1 | One-cycle end-of-conversion pulse |
| resultO | output | CNT_W | Latched conversion count |
| ovrO | output | 1 | Overrange flag for the latched result |
| selSigO | output | 1 | Connect integrator to the input signal |
| selRefO | output | 1 | Connect integrator to the negative reference |
| selHoldO | output | 1 | Hold/discharge setting of the integrator |

## Verification
On every cycle, the assertions check the one-hot switch selects, the bound on the counter, and the fixed length of the integrate phase. They also check that the counter is zero at the switch to the reference, that the done state lasts one cycle, and that a running discharge cannot fall back into an integrate. The scenarios with a behavioural integrator are the only way to show the things that depend on an analog loop. These are the ratio-accurate result, its independence from the clock period, the overrange saturation under an oversized input, and that a start pulse during a conversion is ignored.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_DEINT = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic latchRes;
    logic ovr;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic chargeEnd;
    logic atMax;
    logic zeroSeen;
  } dpStat_t;

endpackage

// File: rtl/dslope_dp.sv
module dslope_dp
  import dslope_pkg::*;
#(
  parameter int N_CHARGE    = 64,
  parameter int MAX_COUNT   = 2 * N_CHARGE,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             compI,
  input  dpCmd_t           cmd,
  output dpStat_t          stat,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] resultO,
  output logic             ovrO
);

  localparam logic [CNT_W-1:0] CHG_LAST = CNT_W'(N_CHARGE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_COUNT);
  localparam logic [CNT_W-1:0] SYNC_LAT = CNT_W'(SYNC_STAGES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   compSync;
  logic [CNT_W-1:0]       corrCnt;

  // comparator synchroniser chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= compI;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], compI};
    end
  endgenerate
  assign compSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.cntClr)  cnt <= '0;
    else if (cmd.cntInc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign corrCnt = (cnt > SYNC_LAT) ? (cnt - SYNC_LAT) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultO <= '0;
      ovrO    <= 1'b0;
    end else if (cmd.latchRes) begin
      resultO <= cmd.ovr ? CNT_MAX : corrCnt;
      ovrO    <= cmd.ovr;
    end
  end

  assign stat.chargeEnd = (cnt == CHG_LAST);
  assign stat.atMax     = (cnt == CNT_MAX);
  assign stat.zeroSeen  = (cnt != '0) && !compSync;

  p_cnt_bound_r6 : assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_MAX);

  p_ovr_sat_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (cmd.latchRes && cmd.ovr) |=> (ovrO && resultO == CNT_MAX));

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startI,
  input  dpStat_t   stat,
  output dpCmd_t    cmd,
  output seqState_t state,
  output logic      busyO,
  output logic      doneO,
  output logic      selSigO,
  output logic      selRefO,
  output logic      selHoldO
);

  seqState_t stateNxt;

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    unique case (state)
      ST_IDLE: if (startI) begin
        stateNxt   = ST_INTEG;
        cmd.cntClr = 1'b1;
      end
      ST_INTEG: begin
        if (stat.chargeEnd) begin
          stateNxt   = ST_DEINT;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_DEINT: begin
        if (stat.zeroSeen) begin
          stateNxt     = ST_DONE;
          cmd.latchRes = 1'b1;
        end else if (stat.atMax) begin
          stateNxt     = ST_DONE;
          cmd.latchRes = 1'b1;
          cmd.ovr      = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;

  assign busyO    = (state != ST_IDLE);
  assign doneO    = (state == ST_DONE);
  assign selSigO  = (state == ST_INTEG);
  assign selRefO  = (state == ST_DEINT);
  assign selHoldO = (state == ST_IDLE) || (state == ST_DONE);

  p_integ_len_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INTEG && !stat.chargeEnd) |=> state == ST_INTEG);

  p_done_pulse_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE));

  p_no_restart_r1 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEINT) |=> (state != ST_INTEG));

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int N_CHARGE    = 64,
  parameter int MAX_COUNT   = 2 * N_CHARGE,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic             compI,
  output logic             busyO,
  output logic             doneO,
  output logic [CNT_W-1:0] resultO,
  output logic             ovrO,
  output logic             selSigO,
  output logic             selRefO,
  output logic             selHoldO
);

  dpCmd_t           cmd;
  dpStat_t          stat;
  seqState_t        state;
  logic [CNT_W-1:0] cnt;

  dslope_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startI(startI), .stat(stat), .cmd(cmd),
    .state(state), .busyO(busyO), .doneO(doneO),
    .selSigO(selSigO), .selRefO(selRefO), .selHoldO(selHoldO)
  );

  dslope_dp #(
    .N_CHARGE(N_CHARGE), .MAX_COUNT(MAX_COUNT),
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .compI(compI), .cmd(cmd), .stat(stat),
    .cnt(cnt), .resultO(resultO), .ovrO(ovrO)
  );

  p_sel_onehot_r8 : assert property (@(posedge clk) disable iff (!rstN)
    $countones({selSigO, selRefO, selHoldO}) == 1);

  p_ref_clear_r3 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(selRefO) |-> (cnt == '0));

endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb_top;

  localparam int N_CHARGE  = 64;
  localparam int MAX_COUNT = 2 * N_CHARGE;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);

  logic clk = 1'b0, rstN = 1'b0, startI = 1'b0, compI;
  logic busyO, doneO, ovrO, selSigO, selRefO, selHoldO;
  logic [CNT_W-1:0] resultO;

  real halfPer = 10.0;
  real vin = 0.0, vref = 1.0, vInt = 0.0;
  int  nVec = 0, nBad = 0, cyc = 0;
  bit  finished = 0;

  dslope_seq dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .compI(compI),
    .busyO(busyO), .doneO(doneO), .resultO(resultO), .ovrO(ovrO),
    .selSigO(selSigO), .selRefO(selRefO), .selHoldO(selHoldO)
  );

  always #(halfPer) clk = ~clk;

  // behavioural integrator: rate scales with the elapsed clock period
  always @(negedge clk) begin
    if (selHoldO)     vInt = 0.0;
    else if (selSigO) vInt = vInt + vin  * 2.0 * halfPer;
    else if (selRefO) vInt = vInt - vref * 2.0 * halfPer;
  end
  assign compI = (vInt > 0.0);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      nBad++;
      $display("FAIL watchdog: actual run>150000 cycles expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string msg,
                     input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, msg, act, exp);
    end
  endtask

  // one conversion; optional stray start pulses while busy
  task automatic run_conv(input real v, input bit stray, output int res, output bit ov);
    int  sigC = 0, refC = 0, idx = 0;
    bit  badHot = 0, gapBad = 0, prevSig = 0, busyBad = 0;
    vin = v;
    @(negedge clk); startI = 1'b1;
    @(negedge clk); startI = 1'b0;
    do begin
      if ($countones({selSigO, selRefO, selHoldO}) != 1) badHot = 1;
      if (!busyO) busyBad = 1;
      if (selSigO) sigC++;
      if (selRefO) begin
        if (refC == 0 && !prevSig) gapBad = 1;
        refC++;
      end
      prevSig = selSigO;
      idx++;
      if (stray && (idx == 10 || refC == 5)) startI = 1'b1;
      else startI = 1'b0;
      if (!doneO) @(negedge clk);
    end while (!doneO);
    startI = 1'b0;
    res = int'(resultO);
    ov  = ovrO;
    chk(!badHot, "R8", "selects one-hot during conversion", badHot, 0);
    chk(!busyBad, "R1", "busy held through conversion", busyBad, 0);
    chk(sigC == N_CHARGE, "R2", "signal-select cycles", sigC, N_CHARGE);
    chk(!gapBad && refC > 0, "R3", "reference follows charge directly", gapBad, 0);
    chk(selHoldO, "R7", "hold in done cycle", selHoldO, 1);
    @(negedge clk);
    chk(!doneO, "R7", "done one cycle wide", doneO, 0);
    chk(selHoldO && !busyO, "R7", "hold and idle after done", busyO, 0);
  endtask

  task automatic check_ratio(input real v, input string tag);
    int res; bit ov; real x, d;
    run_conv(v, 0, res, ov);
    x = N_CHARGE * v / vref;
    d = res - x; if (d < 0.0) d = -d;
    chk(d <= 1.0, "R4", tag, res, int'(x));
    chk(!ov, "R6", {tag, " overrange clear"}, ov, 0);
  endtask

  task automatic t_reset();
    chk(selHoldO && !selSigO && !selRefO, "R9", "hold after reset", selHoldO, 1);
    chk(!busyO && !doneO, "R9", "busy/done after reset", busyO + doneO, 0);
    chk(resultO == 0 && !ovrO, "R9", "result after reset", int'(resultO), 0);
  endtask

  task automatic t_clock();
    int r1, r2; bit o1, o2;
    halfPer = 10.0; run_conv(0.37, 0, r1, o1);
    halfPer = 15.0; run_conv(0.37, 0, r2, o2);
    halfPer = 10.0;
    chk(r1 == r2, "R5", "result equal at 20ns and 30ns", r2, r1);
  endtask

  task automatic t_overrange();
    int res; bit ov;
    run_conv(2.5, 0, res, ov);
    chk(ov, "R6", "overrange flag", ov, 1);
    chk(res == MAX_COUNT, "R6", "saturated result", res, MAX_COUNT);
    check_ratio(0.5, "recovery after overrange");
  endtask

  task automatic t_stray_start();
    int res; bit ov, woke = 0; real x, d;
    run_conv(0.37, 1, res, ov);
    x = N_CHARGE * 0.37 / vref;
    d = res - x; if (d < 0.0) d = -d;
    chk(d <= 1.0, "R1", "result unaffected by stray start", res, int'(x));
    repeat (10) begin
      @(negedge clk);
      if (busyO) woke = 1;
    end
    chk(!woke, "R1", "no conversion from stray start", woke, 0);
    chk(int'(resultO) == res, "R1", "result held while idle", int'(resultO), res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    check_ratio(0.37, "ratio 0.37");
    check_ratio(0.0,  "zero input");
    check_ratio(1.5,  "ratio 1.5");
    check_ratio(0.02, "small input");
    t_clock();
    t_overrange();
    t_stray_start();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule